// File: doc/BRIEF.md
# Three-Wire Configuration Port with Serial Readback

This block is the slave end of a three-wire configuration link: a serial clock, a serial data line and a latch strobe. It loads eleven 32-bit configuration registers and can return one 16-bit status word on a separate serial output. The host shifts a 32-bit word in, most significant bit first. The low four bits of that word name the destination register. A rising edge on the latch strobe copies the word into that register. The register contents are presented in parallel to the rest of the chip.

Register 7 has two roles. When it is written with its readback-enable bit set, the port captures a status word at the moment of the latch. The host then keeps the strobe high and keeps pulsing the serial clock, and the port shifts the status word out. The first bit after the latch is a filler bit, and the sixteen status bits follow it. A three-bit select field in register 7 decides the content of the status word. It can be a signed frequency-offset value, a signal level with two gain codes, a supply/ADC/temperature sample, a fixed identification word, or a filter calibration value. The analog measurements come in as parallel input buses.

All three serial inputs and the enable input are brought into the system clock domain through a two-flop synchronizer. The port acts on the edges it detects there. While the enable input is low, the port ignores all serial activity.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, all eleven registers read as zero and the serial output is low.
- R2: Each rising serial clock edge shifts in one data bit, most significant bit first. A rising latch edge copies the 32-bit word into the register whose index equals word bits 3:0. Register k appears on `cfg_regs_o[32*k+31 : 32*k]`.
- R3: A latch with word bits 3:0 in the range 11 to 15 changes no register.
- R4: While the enable input is low, the port ignores serial clock and latch edges, clears the partial input word and holds the serial output low. Register contents are kept.
- R5: A readback starts only on a latch of a word with bits 3:0 = 7 and bit 8 = 1. If bit 8 = 0, register 7 is written and the serial output stays low.
- R6: During a readback, each rising serial clock edge puts the next bit on the serial output. The first bit is a filler 0. The 16 status bits follow, most significant first, and zeros follow after them.
- R7: A falling latch strobe ends the readback and drives the serial output low. Later clock edges send nothing until a new readback starts.
- R8: The select field is word bits 6:4 of the readback word. Code 0 returns the 16-bit signed frequency offset `freq_i` in all 16 bits.
- R9: Code 1 returns the level in bits 6:0, the filter gain in bits 8:7 and the LNA gain in bits 10:9, with bits 15:11 zero.
- R10: Code 2 returns the supply/ADC/temperature sample in bits 6:0, with bits 15:7 zero.
- R11: Code 3 returns the fixed word 0x2030 (product code 0x20 in bits 15:8, revision 0x30 in bits 7:0). This works as the first access after reset.
- R12: Code 4 returns the filter calibration value in bits 7:0, with bits 15:8 zero. Codes 5 to 7 return an all-zero word.
- R13: The status word is sampled at the latch edge. Changes to the measurement inputs during the shift-out do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Port enable; low makes the port inactive |
| sclk | input | 1 | Serial clock from the host |
| sdata | input | 1 | Serial data from the host |
| sle | input | 1 | Latch strobe; held high during readback |
| freq_i | input | 16 | Signed frequency-offset measurement |
| level_i | input | 7 | Signal level measurement |
| fgain_i | input | 2 | Current filter gain code |
| lgain_i | input | 2 | Current LNA gain code |
| supply_i | input | 7 | Supply/ADC/temperature sample |
| fcal_i | input | 8 | Filter calibration value |
| sread | output | 1 | Serial readback output |
| cfg_regs_o | output | 352 | Eleven 32-bit registers, register k at bits 32k+31:32k |

## Verification
The properties assume that the host never raises the latch strobe in the same synchronized cycle as a serial clock edge. They also assume that the strobe starts low after reset, so that the only latch edges are deliberate ones. The bench holds every serial level for six system clocks and changes one pin at a time. Each edge therefore reaches the synchronizer outputs by itself. The enable input changes only while the clock and strobe are both low. This keeps the assumption that the enable cannot cut a pulse in half.

// File: rtl/csp_pkg.sv
package csp_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int NUM_REGS  = 11;
    localparam int RB_W      = 16;
    localparam int RB_REG    = 7;
    localparam int RB_EN_BIT = 8;
    localparam int MODE_LSB  = 4;
    localparam int MODE_W    = 3;
    localparam int SYNC_DEPTH = 2;
    localparam logic [7:0] PROD_CODE = 8'h20;
    localparam logic [7:0] REV_CODE  = 8'h30;

    typedef enum logic [MODE_W-1:0] {
        RB_FREQ   = 3'd0,
        RB_LEVEL  = 3'd1,
        RB_SUPPLY = 3'd2,
        RB_ID     = 3'd3,
        RB_FCAL   = 3'd4
    } rb_mode_e;

    typedef struct packed {
        logic [15:0] freq;
        logic [6:0]  level;
        logic [1:0]  fgain;
        logic [1:0]  lgain;
        logic [6:0]  supply;
        logic [7:0]  fcal;
    } meas_t;

    typedef struct packed {
        logic ce_lvl;
        logic sclk_rise;
        logic sle_rise;
        logic sle_fall;
        logic data;
    } evt_t;

    function automatic logic [RB_W-1:0] rb_format(input logic [MODE_W-1:0] mode,
                                                  input meas_t m);
        logic [RB_W-1:0] w;
        w = '0;
        case (rb_mode_e'(mode))
            RB_FREQ:   w = m.freq;
            RB_LEVEL:  w = {5'b0, m.lgain, m.fgain, m.level};
            RB_SUPPLY: w = {9'b0, m.supply};
            RB_ID:     w = {PROD_CODE, REV_CODE};
            RB_FCAL:   w = {8'b0, m.fcal};
            default:   w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/csp_sync.sv
module csp_sync
    import csp_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sclk,
    input  logic sdata,
    input  logic sle,
    output evt_t evt
);
    // lane order: {ce, sle, sclk, sdata}
    logic [3:0] pipe [STAGES];
    logic [3:0] last;
    logic [3:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            last <= '0;
        end else begin
            pipe[0] <= {ce, sle, sclk, sdata};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            last <= pipe[STAGES-1];
        end
    end

    assign cur = pipe[STAGES-1];

    always_comb begin
        evt.ce_lvl    = cur[3];
        evt.sle_rise  = cur[3] & cur[2] & ~last[2];
        evt.sle_fall  = ~cur[2] & last[2];
        evt.sclk_rise = cur[3] & cur[1] & ~last[1];
        evt.data      = cur[0];
    end
endmodule

// File: rtl/csp_shift_in.sv
module csp_shift_in
    import csp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lvl,
    input  logic              sclk_rise,
    input  logic              data,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || !ce_lvl) begin
            word <= '0;
        end else if (sclk_rise) begin
            word <= {word[WORD_W-2:0], data};
        end
    end
endmodule

// File: rtl/csp_reg_bank.sv
module csp_reg_bank
    import csp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [WORD_W-1:0]          word,
    output logic [NUM_REGS*WORD_W-1:0] regs
);
    logic [ADDR_W-1:0] addr;
    assign addr = word[ADDR_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr && addr == ADDR_W'(g)) begin
                q <= word;
            end
        end
        assign regs[g*WORD_W +: WORD_W] = q;
    end
endmodule

// File: rtl/csp_readback.sv
module csp_readback
    import csp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lvl,
    input  logic              sle_rise,
    input  logic              sle_fall,
    input  logic              sclk_rise,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rb_en,
    input  logic [MODE_W-1:0] mode,
    input  meas_t             meas,
    output logic              sread
);
    localparam int SH_W = RB_W + 1;

    logic            active;
    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !ce_lvl) begin
            active <= 1'b0;
            sh     <= '0;
            sread  <= 1'b0;
        end else if (sle_rise) begin
            if (addr == ADDR_W'(RB_REG) && rb_en) begin
                active <= 1'b1;
                sh     <= {1'b0, rb_format(mode, meas)};
            end else begin
                active <= 1'b0;
                sh     <= '0;
            end
        end else if (sle_fall) begin
            active <= 1'b0;
            sh     <= '0;
            sread  <= 1'b0;
        end else if (sclk_rise && active) begin
            sread <= sh[SH_W-1];
            sh    <= {sh[SH_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import csp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ce,
    input  logic                       sclk,
    input  logic                       sdata,
    input  logic                       sle,
    input  logic [15:0]                freq_i,
    input  logic [6:0]                 level_i,
    input  logic [1:0]                 fgain_i,
    input  logic [1:0]                 lgain_i,
    input  logic [6:0]                 supply_i,
    input  logic [7:0]                 fcal_i,
    output logic                       sread,
    output logic [NUM_REGS*WORD_W-1:0] cfg_regs_o
);
    evt_t              evt;
    meas_t             meas;
    logic [WORD_W-1:0] shift_word;
    logic              ce_lvl, sclk_rise, sle_rise, sle_fall;

    assign ce_lvl    = evt.ce_lvl;
    assign sclk_rise = evt.sclk_rise;
    assign sle_rise  = evt.sle_rise;
    assign sle_fall  = evt.sle_fall;

    always_comb begin
        meas.freq   = freq_i;
        meas.level  = level_i;
        meas.fgain  = fgain_i;
        meas.lgain  = lgain_i;
        meas.supply = supply_i;
        meas.fcal   = fcal_i;
    end

    csp_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .sdata(sdata), .sle(sle), .evt(evt)
    );

    csp_shift_in u_shift (
        .clk(clk), .rst(rst), .ce_lvl(ce_lvl), .sclk_rise(sclk_rise),
        .data(evt.data), .word(shift_word)
    );

    csp_reg_bank u_bank (
        .clk(clk), .rst(rst), .wr(sle_rise), .word(shift_word), .regs(cfg_regs_o)
    );

    csp_readback u_rb (
        .clk(clk), .rst(rst), .ce_lvl(ce_lvl), .sle_rise(sle_rise), .sle_fall(sle_fall),
        .sclk_rise(sclk_rise), .addr(shift_word[ADDR_W-1:0]),
        .rb_en(shift_word[RB_EN_BIT]), .mode(shift_word[MODE_LSB +: MODE_W]),
        .meas(meas), .sread(sread)
    );
endmodule

// File: rtl/csp_checker.sv
module csp_checker
    import csp_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       ce_lvl,
    input logic                       sle_rise,
    input logic                       sle_fall,
    input logic [WORD_W-1:0]          shift_word,
    input logic [NUM_REGS*WORD_W-1:0] cfg_regs_o,
    input logic                       sread
);
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] picked;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
            word_q <= '0;
        end else begin
            wr_q   <= sle_rise;
            addr_q <= shift_word[ADDR_W-1:0];
            word_q <= shift_word;
        end
    end

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (addr_q == ADDR_W'(k)) picked = cfg_regs_o[k*WORD_W +: WORD_W];
    end

    // R2: an addressed latch lands the shifted word in the named register
    a_r2_latch_lands: assert property (@(posedge clk) disable iff (rst)
        wr_q && int'(addr_q) < NUM_REGS |-> picked == word_q);

    // R3: out-of-range addresses leave the bank untouched
    a_r3_high_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        sle_rise && int'(shift_word[ADDR_W-1:0]) >= NUM_REGS |=> $stable(cfg_regs_o));

    // R4: disabled port neither writes nor talks
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !ce_lvl |=> $stable(cfg_regs_o) && !sread);

    // R6: no data bit appears in the cycle a latch is taken
    a_r6_no_early_data: assert property (@(posedge clk) disable iff (rst)
        sle_rise |=> !sread);

    // R7: dropping the strobe silences the output
    a_r7_fall_silences: assert property (@(posedge clk) disable iff (rst)
        sle_fall |=> !sread);
endmodule

bind cfg_serial_port csp_checker u_chk (
    .clk(clk), .rst(rst), .ce_lvl(ce_lvl), .sle_rise(sle_rise), .sle_fall(sle_fall),
    .shift_word(shift_word), .cfg_regs_o(cfg_regs_o), .sread(sread)
);

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
    localparam int CLK_P = 10;
    localparam int HALF  = 6;
    localparam int NR    = 11;

    logic clk = 0, rst = 1, ce = 1, sclk = 0, sdata = 0, sle = 0;
    logic [15:0] freq_i = '0;
    logic [6:0]  level_i = '0, supply_i = '0;
    logic [1:0]  fgain_i = '0, lgain_i = '0;
    logic [7:0]  fcal_i = '0;
    logic        sread;
    logic [NR*32-1:0] cfg_regs_o;

    cfg_serial_port u0 (
        .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .sdata(sdata), .sle(sle),
        .freq_i(freq_i), .level_i(level_i), .fgain_i(fgain_i), .lgain_i(lgain_i),
        .supply_i(supply_i), .fcal_i(fcal_i), .sread(sread), .cfg_regs_o(cfg_regs_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int tests = 0, fails = 0;
    int drive_seq = 0, seen_seq = 0, quiet = 0;
    bit done = 0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [31:0] m_regs [NR];
    logic [31:0] m_shift = '0;
    logic        m_sread = 0;
    bit          m_rb_on = 0;
    logic        m_rbq [$];

    function automatic logic [15:0] exp_word(int mode);
        case (mode)
            0: return freq_i;
            1: return (16'(lgain_i) << 9) | (16'(fgain_i) << 7) | 16'(level_i);
            2: return 16'(supply_i);
            3: return 16'h2030;
            4: return 16'(fcal_i);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_rise(logic b);
        if (ce) begin
            m_shift = {m_shift[30:0], b};
            if (sle && m_rb_on) m_sread = (m_rbq.size() > 0) ? m_rbq.pop_front() : 1'b0;
        end
    endtask

    task automatic model_latch();
        if (ce) begin
            int a = int'(m_shift[3:0]);
            if (a < NR) m_regs[a] = m_shift;
            m_rbq.delete();
            m_rb_on = (a == 7) && m_shift[8];
            if (m_rb_on) begin
                logic [15:0] w = exp_word(int'(m_shift[6:4]));
                m_rbq.push_back(1'b0);
                for (int i = 15; i >= 0; i--) m_rbq.push_back(w[i]);
            end
        end
    endtask

    task automatic model_fall();
        m_rb_on = 0; m_rbq.delete(); m_sread = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clk_bit(logic b);
        sdata = b; drive_seq++; wait_cyc(HALF);
        sclk = 1; drive_seq++; model_rise(b); wait_cyc(HALF);
        sclk = 0; drive_seq++; wait_cyc(HALF);
    endtask

    task automatic write_word(logic [31:0] w, bit keep_high);
        for (int i = 31; i >= 0; i--) clk_bit(w[i]);
        sle = 1; drive_seq++; model_latch(); wait_cyc(2*HALF);
        if (!keep_high) begin
            sle = 0; drive_seq++; model_fall(); wait_cyc(2*HALF);
        end
    endtask

    task automatic readback(int mode, int pulses);
        write_word(32'h0000_0107 | (32'(mode) << 4), 1);
        for (int i = 0; i < pulses; i++) clk_bit(1'b1);
        sle = 0; drive_seq++; model_fall(); wait_cyc(2*HALF);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison once the synchronizer has settled
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (drive_seq != seen_seq) begin
                seen_seq = drive_seq; quiet = 0;
            end else begin
                quiet++;
            end
            if (quiet >= 3) begin
                check({cur_tag, " sread"}, 32'(sread), 32'(m_sread));
                for (int r = 0; r < NR; r++)
                    if (cfg_regs_o[r*32 +: 32] !== m_regs[r])
                        check({cur_tag, " regs"}, cfg_regs_o[r*32 +: 32], m_regs[r]);
                tests++;
            end
        end
    end

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            done = 1; tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) m_regs[r] = '0;
        wait_cyc(4);
        rst = 0; drive_seq++;
        wait_cyc(6);
        // R1: reset state
        check("R1 sread", 32'(sread), 32'h0);
        for (int r = 0; r < NR; r++) check("R1 regs", cfg_regs_o[r*32 +: 32], 32'h0);

        // R11: identification word as first access after reset
        cur_tag = "R11"; readback(3, 20);

        // R2: write every register with a distinct pattern
        cur_tag = "R2";
        for (int r = 0; r < NR; r++)
            write_word({4'(r), 24'hA5C3E1 ^ 24'(r * 24'h111111), 4'(r)}, 0);
        // R3: addresses 11..15 are ignored
        cur_tag = "R3";
        write_word(32'hFFFF_FFFB, 0);
        write_word(32'h1234_567F, 0);

        // R5: reg 7 without enable bit, then pulses with strobe high
        cur_tag = "R5";
        write_word(32'h0000_0037, 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b1);
        sle = 0; drive_seq++; model_fall(); wait_cyc(2*HALF);

        // R8 / R6: signed frequency offset, full 16 bits plus trailing zeros
        cur_tag = "R8"; freq_i = 16'h8001; readback(0, 20);
        cur_tag = "R6"; freq_i = 16'h6B2D; readback(0, 18);

        // R9: level with gain codes
        cur_tag = "R9"; level_i = 7'h55; fgain_i = 2'd2; lgain_i = 2'd1; readback(1, 18);
        // R10: supply sample
        cur_tag = "R10"; supply_i = 7'h7F; readback(2, 18);
        // R12: calibration value and unused select codes
        cur_tag = "R12"; fcal_i = 8'hA5; readback(4, 18);
        readback(6, 18);

        // R13: measurement changes during shift-out are not seen
        cur_tag = "R13"; freq_i = 16'hF00F;
        write_word(32'h0000_0107, 1);
        freq_i = 16'h0FF0; drive_seq++;
        for (int i = 0; i < 18; i++) clk_bit(1'b1);
        sle = 0; drive_seq++; model_fall(); wait_cyc(2*HALF);

        // R7: strobe drops mid-readback, later pulses send nothing
        cur_tag = "R7"; freq_i = 16'hFFFF;
        write_word(32'h0000_0107, 1);
        for (int i = 0; i < 5; i++) clk_bit(1'b1);
        sle = 0; drive_seq++; model_fall(); wait_cyc(2*HALF);
        for (int i = 0; i < 4; i++) clk_bit(1'b1);

        // R4: disabled port ignores a full write and a readback attempt
        cur_tag = "R4";
        ce = 0; drive_seq++; m_shift = '0; model_fall(); wait_cyc(2*HALF);
        write_word(32'hDEAD_BEE2, 0);
        write_word(32'h0000_0107, 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b1);
        sle = 0; drive_seq++; model_fall(); wait_cyc(2*HALF);
        ce = 1; drive_seq++; wait_cyc(2*HALF);
        // after re-enable the partial word starts clean
        cur_tag = "R2";
        write_word(32'hCAFE_0001, 0);

        wait_cyc(6);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule